// File: doc/BRIEF.md
# Completion Interrupt Message Coalescer

This block decides when a descriptor engine should tell software that work has finished. It does not drive a level interrupt line. Instead it asks a bus master to perform one memory write, and the address and data of that write are taken from configuration registers. The block watches the number of finished descriptors that software has not yet handled, along with a pulse that marks each new completion. It batches notifications in two ways. It raises a message as soon as the pending count reaches a programmed threshold. If the timeout is enabled, it also raises one when a programmed number of clock cycles has passed since the first unhandled completion.

Only one message can be in flight at a time. The request stays valid, with its address and data frozen, until the bus master accepts it. Any trigger that arrives while the message is waiting is folded into that message. After acceptance, the block sends another message only once a new completion has been reported. The timer restarts from zero at every acceptance and whenever the pending count falls to zero. Software programs the block through a small write-only register port. The registers are: control at 0x00, with the count threshold in bits [14:0] and the timeout enable in bit 16; timer limit at 0x04, in bits [12:0]; address low at 0x08; address high at 0x0C, of which only bits [15:0] are kept; and message data at 0x10.

Top module: `imc_coalescer`

## Requirements
- R1: Out of reset, no message is pending. The count threshold is 0x14, the timer limit is 0xB0, the timeout is disabled, and the message address and data are zero.
- R2: A write to 0x08 sets message address bits [31:0]. A write to 0x0C sets message address bits [47:32] from write data bits [15:0], and the upper data bits are dropped. A write to 0x10 sets the message data. A write to 0x00 sets the threshold from bits [14:0] and the timeout enable from bit 16.
- R3: Once a completion pulse has been seen since the last accepted message, a pending count at or above the threshold makes msg_valid rise on the next clock edge. With the count already high when the pulse arrives, msg_valid is visible after the second edge following the pulse.
- R4: No message is raised while the pending count is zero.
- R5: With the timeout enabled and a count below the threshold, a completion pulse sampled at edge 1 makes msg_valid rise at edge L+2, where L is the timer limit. Before that edge, msg_valid stays low.
- R6: With the timeout disabled, a count below the threshold never raises a message, however long it persists.
- R7: A pending count of zero clears the timer and discards the completion seen so far. A later nonzero count raises nothing until a new completion pulse arrives.
- R8: While msg_valid is high and msg_ready is low, msg_valid stays high and msg_addr and msg_data do not change, even if the configuration registers are rewritten.
- R9: Triggers and completion pulses that occur while a message waits for acceptance are merged into it. If no completion pulse coincides with acceptance, no second message follows.
- R10: Acceptance, which is msg_valid and msg_ready high on the same edge, drops msg_valid on that edge and restarts the timer. If a completion pulse coincides with acceptance, the timeout measures a full L cycles from that edge.
- R11: Message address and data are captured from the registers when the message is raised, so values written while a message waits apply to the next message.
- R12: A threshold of zero raises a message for any nonzero pending count after a completion pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| pend_cnt | input | 15 | Completed descriptors not yet handled by software |
| done_pulse | input | 1 | One-cycle pulse per newly completed descriptor batch |
| msg_ready | input | 1 | Bus master accepts the message write |
| msg_valid | output | 1 | Message write request |
| msg_addr | output | 48 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The hardest situations to reach from the ports involve a message that is already waiting. The first is merging triggers into it: the bench holds msg_ready low and pulses completions and raises the count while it waits, then accepts the message with no pulse and confirms that nothing follows. The second is a completion that lands on the very edge of acceptance. The bench drives done_pulse and msg_ready together and checks that the timeout fires exactly L+1 edges later, which shows the timer restarted from zero at acceptance while the arm state survived.

// File: rtl/imc_pkg.sv
package imc_pkg;

    localparam int REG_AW    = 5;
    localparam int WORD_W    = 32;
    localparam int ADDR_LO_W = 32;
    localparam int ADDR_HI_W = 16;
    localparam int ADDR_W    = ADDR_LO_W + ADDR_HI_W;
    localparam int DATA_W    = 32;
    localparam int TMR_EN_BIT = 16;

    localparam logic [REG_AW-1:0] OFS_CTRL = 5'h00;
    localparam logic [REG_AW-1:0] OFS_TLIM = 5'h04;
    localparam logic [REG_AW-1:0] OFS_ALO  = 5'h08;
    localparam logic [REG_AW-1:0] OFS_AHI  = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_DATA = 5'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_TLIM,
        SEL_ALO,
        SEL_AHI,
        SEL_DATA
    } reg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } msg_t;

    function automatic reg_sel_e decode_ofs(input logic [REG_AW-1:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_CTRL: s = SEL_CTRL;
            OFS_TLIM: s = SEL_TLIM;
            OFS_ALO:  s = SEL_ALO;
            OFS_AHI:  s = SEL_AHI;
            OFS_DATA: s = SEL_DATA;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/imc_regs.sv
module imc_regs
    import imc_pkg::*;
#(
    parameter int CNT_W    = 15,
    parameter int TMR_W    = 13,
    parameter int RST_THR  = 20,
    parameter int RST_TLIM = 176
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [REG_AW-1:0]   ofs,
    input  logic [WORD_W-1:0]   wdata,
    output logic [CNT_W-1:0]    thr,
    output logic [TMR_W-1:0]    tlim,
    output logic                tmr_en,
    output msg_t                cfg
);

    logic unused_wbits;
    assign unused_wbits = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr    <= RST_THR[CNT_W-1:0];
            tlim   <= RST_TLIM[TMR_W-1:0];
            tmr_en <= 1'b0;
            cfg    <= '0;
        end else if (we) begin
            case (decode_ofs(ofs))
                SEL_CTRL: begin
                    thr    <= wdata[CNT_W-1:0];
                    tmr_en <= wdata[TMR_EN_BIT];
                end
                SEL_TLIM: tlim <= wdata[TMR_W-1:0];
                SEL_ALO:  cfg.addr[ADDR_LO_W-1:0] <= wdata[ADDR_LO_W-1:0];
                SEL_AHI:  cfg.addr[ADDR_W-1:ADDR_LO_W] <= wdata[ADDR_HI_W-1:0];
                SEL_DATA: cfg.data <= wdata[DATA_W-1:0];
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/imc_timer.sv
module imc_timer #(
    parameter int TMR_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  logic             pend_nz,
    input  logic             accept,
    input  logic             tmr_en,
    input  logic [TMR_W-1:0] tlim,
    output logic             armed,
    output logic [TMR_W-1:0] tmr,
    output logic             expired
);

    // Arm on any completion; disarm when the message is taken or nothing is left.
    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (done)
            armed <= 1'b1;
        else if (accept || !pend_nz)
            armed <= 1'b0;
    end

    // Saturating tick counter, restarted on acceptance or an empty queue.
    always_ff @(posedge clk) begin
        if (rst)
            tmr <= '0;
        else if (accept || !pend_nz || !armed || !tmr_en)
            tmr <= '0;
        else if (tmr < tlim)
            tmr <= tmr + 1'b1;
    end

    assign expired = tmr_en && armed && (tmr >= tlim);

endmodule

// File: rtl/imc_issue.sv
module imc_issue
    import imc_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             armed,
    input  logic [CNT_W-1:0] pend_cnt,
    input  logic [CNT_W-1:0] thr,
    input  logic             expired,
    input  logic             msg_ready,
    input  msg_t             cfg,
    output logic             msg_valid,
    output msg_t             msg,
    output logic             accept
);

    logic count_hit;
    logic fire;

    assign count_hit = pend_cnt >= thr;
    assign fire      = armed && (pend_cnt != '0) && (count_hit || expired);
    assign accept    = msg_valid && msg_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg       <= '0;
        end else if (!msg_valid) begin
            if (fire) begin
                msg_valid <= 1'b1;
                msg       <= cfg;
            end
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/imc_coalescer.sv
module imc_coalescer
    import imc_pkg::*;
#(
    parameter int CNT_W    = 15,
    parameter int TMR_W    = 13,
    parameter int RST_THR  = 20,
    parameter int RST_TLIM = 176
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [REG_AW-1:0]    cfg_addr,
    input  logic [WORD_W-1:0]    cfg_wdata,
    input  logic [CNT_W-1:0]     pend_cnt,
    input  logic                 done_pulse,
    input  logic                 msg_ready,
    output logic                 msg_valid,
    output logic [ADDR_W-1:0]    msg_addr,
    output logic [DATA_W-1:0]    msg_data
);

    logic [CNT_W-1:0] thr;
    logic [TMR_W-1:0] tlim;
    logic             tmr_en;
    msg_t             cfg;
    msg_t             msg;
    logic             armed;
    logic [TMR_W-1:0] tmr;
    logic             expired;
    logic             accept;
    logic             pend_nz;

    assign pend_nz = |pend_cnt;

    imc_regs #(
        .CNT_W   (CNT_W),
        .TMR_W   (TMR_W),
        .RST_THR (RST_THR),
        .RST_TLIM(RST_TLIM)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .ofs   (cfg_addr),
        .wdata (cfg_wdata),
        .thr   (thr),
        .tlim  (tlim),
        .tmr_en(tmr_en),
        .cfg   (cfg)
    );

    imc_timer #(
        .TMR_W(TMR_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .done   (done_pulse),
        .pend_nz(pend_nz),
        .accept (accept),
        .tmr_en (tmr_en),
        .tlim   (tlim),
        .armed  (armed),
        .tmr    (tmr),
        .expired(expired)
    );

    imc_issue #(
        .CNT_W(CNT_W)
    ) u_issue (
        .clk      (clk),
        .rst      (rst),
        .armed    (armed),
        .pend_cnt (pend_cnt),
        .thr      (thr),
        .expired  (expired),
        .msg_ready(msg_ready),
        .cfg      (cfg),
        .msg_valid(msg_valid),
        .msg      (msg),
        .accept   (accept)
    );

    assign msg_addr = msg.addr;
    assign msg_data = msg.data;

endmodule

// File: rtl/imc_coalescer_chk.sv
module imc_coalescer_chk #(
    parameter int CNT_W  = 15,
    parameter int TMR_W  = 13,
    parameter int ADDR_W = 48,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  pend_cnt,
    input logic              done_pulse,
    input logic              msg_ready,
    input logic              msg_valid,
    input logic [ADDR_W-1:0] msg_addr,
    input logic [DATA_W-1:0] msg_data,
    input logic              armed,
    input logic [TMR_W-1:0]  tmr
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> !msg_valid);

    // R8
    hold_msg_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

    // R4
    no_empty_msg_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> $past(pend_cnt) != '0);

    // R3
    needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> $past(armed));

    // R10
    accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_ready |=> !msg_valid);

    // R9
    disarm_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_ready && !done_pulse |=> !armed);

    // R7
    tmr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        pend_cnt == '0 |=> tmr == '0);

endmodule

bind imc_coalescer imc_coalescer_chk #(
    .CNT_W (CNT_W),
    .TMR_W (TMR_W),
    .ADDR_W(imc_pkg::ADDR_W),
    .DATA_W(imc_pkg::DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pend_cnt  (pend_cnt),
    .done_pulse(done_pulse),
    .msg_ready (msg_ready),
    .msg_valid (msg_valid),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .armed     (armed),
    .tmr       (tmr)
);

// File: tb/sim_imc_coalescer.sv
`timescale 1ns/1ps
module sim_imc_coalescer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [14:0] pend = '0;
    logic        done = 1'b0;
    logic        ready = 1'b0;
    logic        valid;
    logic [47:0] maddr;
    logic [31:0] mdata;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    imc_coalescer u0 (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (we),
        .cfg_addr  (addr),
        .cfg_wdata (wdata),
        .pend_cnt  (pend),
        .done_pulse(done),
        .msg_ready (ready),
        .msg_valid (valid),
        .msg_addr  (maddr),
        .msg_data  (mdata)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        tick();
        we = 1'b0;
    endtask

    task automatic pulse();
        done = 1'b1;
        tick();
        done = 1'b0;
    endtask

    task automatic take();
        ready = 1'b1;
        tick();
        ready = 1'b0;
    endtask

    task automatic settle();
        pend = '0;
        tick();
        tick();
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        chk("R1 idle after reset", {63'd0, valid}, 64'd0);

        // R1 / R6: default threshold 0x14, timeout off
        pend = 15'h13;
        pulse();
        repeat (176 + 10) tick();
        chk("R6 no timeout while disabled", {63'd0, valid}, 64'd0);
        pend = 15'h14;
        tick();
        chk("R1 default threshold 0x14", {63'd0, valid}, 64'd1);
        chk("R1 default address", {16'd0, maddr}, 64'd0);
        chk("R1 default data", {32'd0, mdata}, 64'd0);
        take();
        chk("R10 drop on accept", {63'd0, valid}, 64'd0);
        settle();

        // R2 / R11: register fields
        wr(5'h08, 32'h1234_5678);
        wr(5'h0C, 32'hABCD_9876);
        wr(5'h10, 32'hCAFE_F00D);
        wr(5'h00, 32'd3);
        pend = 15'd3;
        pulse();
        chk("R3 not before second edge", {63'd0, valid}, 64'd0);
        tick();
        chk("R3 count trigger", {63'd0, valid}, 64'd1);
        chk("R2 address halves", {16'd0, maddr}, 64'h0000_9876_1234_5678);
        chk("R2 data word", {32'd0, mdata}, 64'h0000_0000_CAFE_F00D);

        // R8 / R9: hold and merge while outstanding
        wr(5'h08, 32'd0);
        wr(5'h10, 32'h0000_0001);
        pulse();
        pend = 15'd7;
        pulse();
        repeat (3) tick();
        chk("R8 valid held", {63'd0, valid}, 64'd1);
        chk("R8 address frozen", {16'd0, maddr}, 64'h0000_9876_1234_5678);
        chk("R8 data frozen", {32'd0, mdata}, 64'h0000_0000_CAFE_F00D);
        take();
        repeat (5) tick();
        chk("R9 merged, no second message", {63'd0, valid}, 64'd0);
        pulse();
        tick();
        chk("R11 new message after pulse", {63'd0, valid}, 64'd1);
        chk("R11 new address captured", {16'd0, maddr}, 64'h0000_9876_0000_0000);
        chk("R11 new data captured", {32'd0, mdata}, 64'd1);
        take();
        settle();

        // R3 / R4: threshold sweep, timeout off
        for (int t = 1; t <= 4; t++) begin
            wr(5'h00, t);
            for (int p = 0; p <= 5; p++) begin
                logic e;
                e = (p != 0) && (p >= t);
                pend = p[14:0];
                pulse();
                tick();
                chk(p == 0 ? "R4 zero pending" : "R3 threshold sweep", {63'd0, valid}, {63'd0, e});
                if (valid) take();
                settle();
            end
        end

        // R12: zero threshold
        wr(5'h00, 32'd0);
        pend = 15'd1;
        pulse();
        tick();
        chk("R12 zero threshold", {63'd0, valid}, 64'd1);
        take();
        settle();

        // R5 / R10: timeout latency sweep
        wr(5'h00, 32'h0001_7FFF);
        for (int l = 0; l <= 6; l++) begin
            wr(5'h04, l);
            pend = 15'd2;
            pulse();
            for (int m = 0; m <= l + 1; m++) begin
                chk("R5 timeout latency", {63'd0, valid}, {63'd0, (m == l + 1)});
                if (m < l + 1) tick();
            end
            take();
            repeat (l + 3) tick();
            chk("R10 timer restarted, no refire", {63'd0, valid}, 64'd0);
            settle();
        end

        // R7: empty queue discards arm and timer
        wr(5'h04, 32'd5);
        pend = 15'd2;
        pulse();
        repeat (3) tick();
        pend = '0;
        tick();
        pend = 15'd2;
        repeat (10) tick();
        chk("R7 cleared by empty queue", {63'd0, valid}, 64'd0);

        // R10: pulse coinciding with acceptance restarts a full window
        wr(5'h04, 32'd4);
        pulse();
        repeat (5) tick();
        chk("R5 fired before accept test", {63'd0, valid}, 64'd1);
        ready = 1'b1; done = 1'b1;
        tick();
        ready = 1'b0; done = 1'b0;
        for (int m = 0; m <= 5; m++) begin
            chk("R10 restart on accept edge", {63'd0, valid}, {63'd0, (m == 5)});
            if (m < 5) tick();
        end
        take();
        settle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule